// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single read or write requests from a processor core into bus cycles on a pin set where the low 16 address lines are shared with data and the top 4 address lines are shared with status bits. Each cycle passes through the states T1, T2 and T3, then zero or more wait states, then T4. The block drives the address latch strobe, the read and write strobes, the transceiver direction and enable, and the active-low byte-high enable. It returns the read data together with a one-cycle done pulse.

A request carries a 20-bit address, a byte/word size flag, 16 bits of write data and a 5-bit status field that is put on the shared pins after the address phase. The shared lines are modelled as a separate output, output-enable and input, so that the pad ring can build the tri-state buffer. The external address latches, transceivers and memory are not part of the block.

Top module: `mux_bus_seq`

## Requirements
- R1: `req_ready_o` is high only in the idle state and in T4. A request that is present with `req_valid_i` while `req_ready_o` is high at a rising clock edge starts T1 in the next cycle. A request offered at any other time is not taken.
- R2: In T1, `ale_o` is high for exactly one cycle and `mux_ad_oe_o` is high. `{ahi_o, mux_ad_o}` carries the 20-bit address, with bit 0 forced to 0 on a word access. Both strobes stay high, and `dir_tx_o` equals the request's write flag.
- R3: Lane select in T1 (`byte_hi_n_o`, address bit 0). A word gives (0,0), both lanes. A byte at an even address gives (1,0), low lane. A byte at an odd address gives (0,1), high lane.
- R4: On a read, from T2 through the last T3 or wait state, `rd_n_o` is 0, `mux_ad_oe_o` is 0, `dir_tx_o` is 0 and `xcvr_en_n_o` is 0. In T4, `rd_n_o` and `xcvr_en_n_o` are 1 and the shared lines stay released.
- R5: On a write, `mux_ad_o` carries the write data from T2 through T4 with `mux_ad_oe_o` at 1, `dir_tx_o` at 1 and `xcvr_en_n_o` at 0. `wr_n_o` is 0 from T2 through the last T3 or wait state and is 1 in T4. A byte write repeats data bits [7:0] on both lanes.
- R6: `ready_i` is sampled at the end of T3 and of every wait state. While it is 0, another wait state follows. A cycle with N wait states puts T4 exactly 3+N cycles after T1.
- R7: From T2 through T4, `ahi_o` carries `req_stat_i[3:0]` and `byte_hi_n_o` carries `req_stat_i[4]`.
- R8: Read data is taken from `mux_ad_i` on the edge that leaves the final T3 or wait state. A word returns all 16 bits. A byte returns the selected lane in bits [7:0], with zeros above. `rsp_rdata_o` holds its value until the next read completes, and write cycles leave it unchanged.
- R9: `rsp_valid_o` is a one-cycle pulse in T4 of every read and write cycle.
- R10: A request taken in T4 goes directly into T1 in the next cycle, with no idle cycle between the two bus cycles.
- R11: In idle and in reset, `ale_o` is 0, both strobes are 1, `mux_ad_oe_o` is 0, `xcvr_en_n_o` is 1, `byte_hi_n_o` is 1, `ahi_o` is 0 and `rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr_i | input | 20 | Byte address |
| req_wdata_i | input | 16 | Write data |
| req_stat_i | input | 5 | Status driven after the address phase |
| rsp_valid_o | output | 1 | Cycle done pulse (T4) |
| rsp_rdata_o | output | 16 | Read data, lane aligned |
| ale_o | output | 1 | Address latch strobe |
| mux_ad_o | output | 16 | Shared address/data lines, out |
| mux_ad_oe_o | output | 1 | Drive enable for the shared lines |
| mux_ad_i | input | 16 | Shared address/data lines, in |
| ahi_o | output | 4 | Upper address or status |
| byte_hi_n_o | output | 1 | Byte-high enable (T1) or status bit |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| dir_tx_o | output | 1 | Transceiver direction, 1 = transmit |
| xcvr_en_n_o | output | 1 | Transceiver enable, active low |
| ready_i | input | 1 | Device ready, high = no wait |

## Verification
A state register stuck or mis-stepped shows at the pins in the same cycle. ALE comes out twice or never, a strobe starts a cycle early or ends a cycle late, or the shared lines are driven while the read strobe is low. A mis-counted wait loop moves the done pulse, so the spacing from T1 to done (3 plus the number of wait states) shows it within one bus cycle. A wrong lane choice or a bad capture edge gives a read value that differs from the bench's shadow memory at the done pulse that ends the same cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;

  function automatic logic is_strobe_st(bus_st_e st);
    return (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  endfunction

  function automatic logic is_sample_st(bus_st_e st);
    return (st == ST_T3) || (st == ST_TW);
  endfunction

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [STAT_W-1:0] req_stat_i,
  input  logic              ready_i,
  output logic              req_ready_o,
  output bus_st_e           state_o,
  output logic              cur_write_o,
  output logic              cur_word_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [DATA_W-1:0] cur_wdata_o,
  output logic [STAT_W-1:0] cur_stat_o,
  output logic              capture_o,
  output logic              done_o
);

  bus_st_e st_q, st_d;
  logic    accept;

  assign req_ready_o = (st_q == ST_IDLE) || (st_q == ST_T4);
  assign accept      = req_ready_o && req_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (req_valid_i) st_d = ST_T1;
      ST_T1:        st_d = ST_T2;
      ST_T2:        st_d = ST_T3;
      ST_T3, ST_TW: st_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:        st_d = req_valid_i ? ST_T1 : ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_write_o <= 1'b0;
      cur_word_o  <= 1'b0;
      cur_addr_o  <= '0;
      cur_wdata_o <= '0;
      cur_stat_o  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        cur_write_o <= req_write_i;
        cur_word_o  <= req_word_i;
        cur_addr_o  <= req_addr_i;
        cur_wdata_o <= req_wdata_i;
        cur_stat_o  <= req_stat_i;
      end
    end
  end

  assign state_o   = st_q;
  assign capture_o = is_sample_st(st_q) && ready_i && !cur_write_o;
  assign done_o    = (st_q == ST_T4);

  // R1
  t1_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T1) |-> $past(req_ready_o && req_valid_i));

  // R6
  wait_insert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sample_st(st_q) && !ready_i) |=> (st_q == ST_TW));

  // R10
  back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T4 && req_valid_i) |=> (st_q == ST_T1));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/mbs_pin_drv.sv
module mbs_pin_drv
  import mbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned HI_W   = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_st_e           state_i,
  input  logic              cur_write_i,
  input  logic              cur_word_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [DATA_W-1:0] cur_wdata_i,
  input  logic [HI_W:0]     cur_stat_i,
  output logic              ale_o,
  output logic [DATA_W-1:0] mux_ad_o,
  output logic              mux_ad_oe_o,
  output logic [HI_W-1:0]   ahi_o,
  output logic              byte_hi_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dir_tx_o,
  output logic              xcvr_en_n_o
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] lo_addr;
  logic [DATA_W-1:0] wdrv;

  // word access is aligned: bit 0 never reaches the pins
  assign lo_addr = {cur_addr_i[DATA_W-1:1], cur_addr_i[0] & ~cur_word_i};
  assign wdrv    = cur_word_i ? cur_wdata_i : {2{cur_wdata_i[BYTE_W-1:0]}};

  always_comb begin
    ale_o       = 1'b0;
    mux_ad_o    = '0;
    mux_ad_oe_o = 1'b0;
    ahi_o       = '0;
    byte_hi_n_o = 1'b1;
    rd_n_o      = 1'b1;
    wr_n_o      = 1'b1;
    dir_tx_o    = 1'b0;
    xcvr_en_n_o = 1'b1;
    unique case (state_i)
      ST_T1: begin
        ale_o       = 1'b1;
        mux_ad_oe_o = 1'b1;
        mux_ad_o    = lo_addr;
        ahi_o       = cur_addr_i[ADDR_W-1:DATA_W];
        byte_hi_n_o = ~(cur_word_i | cur_addr_i[0]);
        dir_tx_o    = cur_write_i;
      end
      ST_T2, ST_T3, ST_TW: begin
        ahi_o       = cur_stat_i[HI_W-1:0];
        byte_hi_n_o = cur_stat_i[HI_W];
        dir_tx_o    = cur_write_i;
        xcvr_en_n_o = 1'b0;
        if (cur_write_i) begin
          mux_ad_oe_o = 1'b1;
          mux_ad_o    = wdrv;
          wr_n_o      = 1'b0;
        end else begin
          rd_n_o      = 1'b0;
        end
      end
      ST_T4: begin
        ahi_o       = cur_stat_i[HI_W-1:0];
        byte_hi_n_o = cur_stat_i[HI_W];
        dir_tx_o    = cur_write_i;
        if (cur_write_i) begin
          mux_ad_oe_o = 1'b1;
          mux_ad_o    = wdrv;
          xcvr_en_n_o = 1'b0;
        end
      end
      default: ;
    endcase
  end

  // R2
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  // R4
  rd_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> (!mux_ad_oe_o && !dir_tx_o && wr_n_o));

  // R5
  wr_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> (mux_ad_oe_o && dir_tx_o && !xcvr_en_n_o));

  // R5
  wr_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |=> (mux_ad_oe_o && $stable(mux_ad_o)));

endmodule

// File: rtl/mbs_rd_cap.sv
module mbs_rd_cap #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              word_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] mux_ad_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] lane_sel;

  always_comb begin
    if (word_i)    lane_sel = mux_ad_i;
    else if (a0_i) lane_sel = {{BYTE_W{1'b0}}, mux_ad_i[DATA_W-1:BYTE_W]};
    else           lane_sel = {{BYTE_W{1'b0}}, mux_ad_i[BYTE_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= lane_sel;
  end

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_o));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned HI_W   = ADDR_W - DATA_W,
  localparam int unsigned STAT_W = HI_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [STAT_W-1:0] req_stat_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              ale_o,
  output logic [DATA_W-1:0] mux_ad_o,
  output logic              mux_ad_oe_o,
  input  logic [DATA_W-1:0] mux_ad_i,
  output logic [HI_W-1:0]   ahi_o,
  output logic              byte_hi_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dir_tx_o,
  output logic              xcvr_en_n_o,
  input  logic              ready_i
);

  bus_st_e           state;
  logic              cur_write, cur_word, capture;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [STAT_W-1:0] cur_stat;

  mbs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_word_i  (req_word_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_stat_i  (req_stat_i),
    .ready_i     (ready_i),
    .req_ready_o (req_ready_o),
    .state_o     (state),
    .cur_write_o (cur_write),
    .cur_word_o  (cur_word),
    .cur_addr_o  (cur_addr),
    .cur_wdata_o (cur_wdata),
    .cur_stat_o  (cur_stat),
    .capture_o   (capture),
    .done_o      (rsp_valid_o)
  );

  mbs_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_W(HI_W)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .cur_write_i (cur_write),
    .cur_word_i  (cur_word),
    .cur_addr_i  (cur_addr),
    .cur_wdata_i (cur_wdata),
    .cur_stat_i  (cur_stat),
    .ale_o       (ale_o),
    .mux_ad_o    (mux_ad_o),
    .mux_ad_oe_o (mux_ad_oe_o),
    .ahi_o       (ahi_o),
    .byte_hi_n_o (byte_hi_n_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .dir_tx_o    (dir_tx_o),
    .xcvr_en_n_o (xcvr_en_n_o)
  );

  mbs_rd_cap #(.DATA_W(DATA_W)) u_rdcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .word_i    (cur_word),
    .a0_i      (cur_addr[0]),
    .mux_ad_i  (mux_ad_i),
    .rdata_o   (rsp_rdata_o)
  );

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (!ale_o && rd_n_o && wr_n_o && !mux_ad_oe_o && xcvr_en_n_o));

endmodule

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_word_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [4:0]  req_stat_i = '0;
  logic        ready_i = 1'b1;
  logic [15:0] mux_ad_i;
  logic        req_ready_o, rsp_valid_o, ale_o, mux_ad_oe_o, byte_hi_n_o;
  logic        rd_n_o, wr_n_o, dir_tx_o, xcvr_en_n_o;
  logic [15:0] rsp_rdata_o, mux_ad_o;
  logic [3:0]  ahi_o;

  mux_bus_seq dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_word_i,
    .req_addr_i, .req_wdata_i, .req_stat_i, .rsp_valid_o, .rsp_rdata_o,
    .ale_o, .mux_ad_o, .mux_ad_oe_o, .mux_ad_i, .ahi_o, .byte_hi_n_o,
    .rd_n_o, .wr_n_o, .dir_tx_o, .xcvr_en_n_o, .ready_i
  );

  typedef struct {
    bit          wr;
    bit          word;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [4:0]  stat;
    int          waits;
    bit          b2b;
    logic [15:0] exp_rd;
  } item_t;

  item_t       q[$];
  item_t       cur;
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  logic [19:0] lat_addr = '0;
  logic        lat_bhe_n = 1'b1;
  logic [15:0] last_rd = '0;
  int vec = 0, bad = 0, cyc = 0, cnt = 0, t1_cyc = 0, rsp_cyc = -10;

  assign mux_ad_i = !rd_n_o ? mem[lat_addr[8:1]] : 16'hDEAD;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] drv_of(item_t it);
    return it.word ? it.wdata : {it.wdata[7:0], it.wdata[7:0]};
  endfunction

  // monitor: device model and scoreboard compare
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ale_o) begin
        if (q.size() == 0) chk(1'b0, "R1", 32'd0, 32'd1);
        else begin
          cur = q.pop_front();
          lat_addr  = {ahi_o, mux_ad_o};
          lat_bhe_n = byte_hi_n_o;
          chk({ahi_o, mux_ad_o} == {cur.addr[19:1], cur.word ? 1'b0 : cur.addr[0]}, "R2",
              {12'h0, ahi_o, mux_ad_o}, {12'h0, cur.addr});
          chk(mux_ad_oe_o && dir_tx_o == cur.wr && rd_n_o && wr_n_o, "R2",
              {mux_ad_oe_o, dir_tx_o, rd_n_o, wr_n_o}, {1'b1, cur.wr, 2'b11});
          chk(byte_hi_n_o == (cur.word ? 1'b0 : ~cur.addr[0]), "R3",
              byte_hi_n_o, cur.word ? 1'b0 : ~cur.addr[0]);
          chk(!req_ready_o, "R1", req_ready_o, 0);
          if (cur.b2b) chk(rsp_cyc == cyc - 1, "R10", rsp_cyc, cyc - 1);
          t1_cyc = cyc;
        end
      end
      if (!rd_n_o || !wr_n_o) begin
        cnt++;
        chk(ahi_o == cur.stat[3:0] && byte_hi_n_o == cur.stat[4], "R7",
            {byte_hi_n_o, ahi_o}, cur.stat);
        if (cur.wr) begin
          chk(!wr_n_o && rd_n_o && mux_ad_oe_o && dir_tx_o && !xcvr_en_n_o && mux_ad_o == drv_of(cur),
              "R5", mux_ad_o, drv_of(cur));
          if (!lat_addr[0]) mem[lat_addr[8:1]][7:0]  = mux_ad_o[7:0];
          if (!lat_bhe_n)   mem[lat_addr[8:1]][15:8] = mux_ad_o[15:8];
        end else begin
          chk(!rd_n_o && wr_n_o && !mux_ad_oe_o && !dir_tx_o && !xcvr_en_n_o, "R4",
              {rd_n_o, wr_n_o, mux_ad_oe_o, dir_tx_o, xcvr_en_n_o}, 5'b01000);
        end
      end else begin
        cnt = 0;
      end
      ready_i = (cnt >= 2 + cur.waits);
      if (rsp_valid_o) begin
        chk(rsp_cyc != cyc - 1, "R9", rsp_cyc, cyc - 2);
        rsp_cyc = cyc;
        chk(cyc - t1_cyc == 3 + cur.waits, "R6", cyc - t1_cyc, 3 + cur.waits);
        chk(ahi_o == cur.stat[3:0] && byte_hi_n_o == cur.stat[4], "R7",
            {byte_hi_n_o, ahi_o}, cur.stat);
        if (cur.wr) begin
          chk(mux_ad_oe_o && mux_ad_o == drv_of(cur) && wr_n_o && rd_n_o && !xcvr_en_n_o && dir_tx_o,
              "R5", mux_ad_o, drv_of(cur));
          chk(rsp_rdata_o == last_rd, "R8", rsp_rdata_o, last_rd);
        end else begin
          chk(rsp_rdata_o == cur.exp_rd, "R8", rsp_rdata_o, cur.exp_rd);
          chk(rd_n_o && xcvr_en_n_o && !mux_ad_oe_o, "R4",
              {rd_n_o, xcvr_en_n_o, mux_ad_oe_o}, 3'b110);
          last_rd = cur.exp_rd;
        end
      end
    end
  end

  // driver: push expected item, then offer request until taken
  task automatic send(input bit wr, input bit word, input logic [19:0] a, input logic [15:0] d,
                      input logic [4:0] st, input int w, input bit b2b);
    item_t it;
    bit acc;
    logic [7:0] idx;
    idx = a[8:1];
    it.wr = wr; it.word = word; it.addr = a; it.wdata = d; it.stat = st;
    it.waits = w; it.b2b = b2b; it.exp_rd = '0;
    if (wr) begin
      if (word)      exp_mem[idx]       = d;
      else if (a[0]) exp_mem[idx][15:8] = d[7:0];
      else           exp_mem[idx][7:0]  = d[7:0];
    end else begin
      if (word)      it.exp_rd = exp_mem[idx];
      else if (a[0]) it.exp_rd = {8'h00, exp_mem[idx][15:8]};
      else           it.exp_rd = {8'h00, exp_mem[idx][7:0]};
    end
    q.push_back(it);
    req_valid_i = 1'b1; req_write_i = wr; req_word_i = word;
    req_addr_i = a; req_wdata_i = d; req_stat_i = st;
    forever begin
      acc = req_ready_o;
      @(posedge clk_i);
      if (acc) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check_idle();
    chk(!ale_o && rd_n_o && wr_n_o && !mux_ad_oe_o && xcvr_en_n_o && byte_hi_n_o && ahi_o == 4'h0
        && !rsp_valid_o, "R11",
        {ale_o, rd_n_o, wr_n_o, mux_ad_oe_o, xcvr_en_n_o, byte_hi_n_o, ahi_o, rsp_valid_o},
        {6'b011011, 4'h0, 1'b0});
    chk(req_ready_o, "R1", req_ready_o, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 16'(i * 16'h0107) ^ 16'hA55A;
      exp_mem[i] = mem[i];
    end
    cur = '{wr: 0, word: 0, addr: '0, wdata: '0, stat: '0, waits: 0, b2b: 0, exp_rd: '0};
    gap(2);
    check_idle();
    gap(1);
    rst_ni = 1'b1;
    gap(1);
    check_idle();
    chk(rsp_rdata_o == 16'h0, "R8", rsp_rdata_o, 0);
    // word write then read back
    send(1, 1, 20'h3A006, 16'hBEEF, 5'h13, 0, 0); gap(6); check_idle();
    send(0, 1, 20'h3A006, 16'h0000, 5'h0A, 0, 0); gap(6);
    // byte lanes
    send(1, 0, 20'h00011, 16'h557C, 5'h1F, 1, 0); gap(7);
    send(1, 0, 20'h00010, 16'h6642, 5'h04, 0, 0); gap(6);
    send(0, 1, 20'h00010, 16'h0000, 5'h11, 2, 0); gap(8);
    send(0, 0, 20'h00011, 16'h0000, 5'h02, 0, 0); gap(6);
    send(0, 0, 20'h00010, 16'h0000, 5'h1C, 3, 0); gap(9);
    // word at odd address is aligned
    send(0, 1, 20'h80025, 16'h0000, 5'h09, 0, 0); gap(6); check_idle();
    // back-to-back run
    send(1, 1, 20'h00040, 16'h1234, 5'h15, 0, 0);
    send(0, 0, 20'h00041, 16'h0000, 5'h06, 1, 1);
    send(1, 0, 20'h00043, 16'h00AB, 5'h18, 0, 1);
    send(0, 1, 20'h00042, 16'h0000, 5'h0F, 2, 1);
    gap(10); check_idle();
    // long wait
    send(0, 1, 20'h00100, 16'h0000, 5'h1E, 5, 0);
    gap(12); check_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    vec++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule